// File: doc/BRIEF.md
# GPIO Pin Interrupt and Wake Detector

This block watches a set of GPIO input pins, grouped into banks of 32, and turns pin activity into one combined interrupt line and one wake line. The port logic supplies the pin values already synchronised to the clock. Each pin can detect a rising edge, a falling edge, both edges, or an active level of either polarity. A detected event is latched in a per-bank source register. A per-bank enable mask selects which latched bits drive the interrupt line. A separate wake mask decides which events are also latched into a wake source register, and that register drives the wake line.

Each pin has a three-clock stability filter in front of the detector, and a per-pin bypass bit can skip it. Software reaches the block through the same 32-bit register bus as the port registers. Each register kind has a fixed base offset. Bank n of that kind sits at base + 4·n. Reads return data one clock after the address is presented. Both source registers are cleared by writing ones.

Top module: `gpio_irq_unit`

## Requirements
- R1: After the synchronous reset, every register reads 0, and `irq_o` and `wake_o` are low.
- R2: The configuration registers read back the value last written. Their bases are: rise enable 0x064, fall enable 0x07c, filter bypass 0x094, interrupt mask 0x0ac, detect type 0x300, level polarity 0x318, wake mask 0x400. Bank n sits at base + 4·n. `bus_rdata_o` shows the register addressed on the previous clock.
- R3: With a pin's rise-enable bit at 1 and its type bit at 0, a 0→1 change at the detector sets that pin's bit in the interrupt source register (base 0x0c4).
- R4: With a pin's fall-enable bit at 1, a 1→0 change sets its source bit. With both enable bits at 1, both directions set it.
- R5: With a pin's type bit at 1, the pin is in level mode. Its source bit is set on every clock in which the pin is active. The pin is active-high when its polarity bit is 0 and active-low when it is 1. Writing 1 clears the bit for that clock, and the bit sets again on the next clock if the level is still active.
- R6: Writing 1 to an edge-mode source bit clears it, and it stays clear until a new enabled edge occurs. Writing 0 has no effect. An edge on the same clock as the clear leaves the bit set.
- R7: `irq_o` is high exactly one clock after any bank has a bit set in both the source register and the interrupt mask register.
- R8: With the bypass bit at 0, a pin change reaches the detector only after the input has differed from the filtered value on 3 consecutive clocks. Shorter pulses are dropped.
- R9: With the bypass bit at 1, the raw pin goes straight to the detector, so a 0→1 change sets the source bit on the same clock.
- R10: The wake source register (base 0x418) latches the same events as the interrupt source register, but only for pins whose wake mask bit is 1. It is cleared by writing 1, with the same level and edge rules as R5 and R6. `wake_o` is high one clock after any wake source bit is set.
- R11: Writes to addresses that hold no register change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NUM_BANKS*32 | Synchronised pin levels, pin p at bit p |
| bus_we_i | input | 1 | Write strobe for the register bus |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt, registered |
| wake_o | output | 1 | Combined wake request, registered |

## Verification
The bench builds the block with NUM_BANKS=2 and STABLE_CYCLES=3. With two banks, every register kind has a mapped second bank, which tests the 4-byte stride, and a third-bank slot (such as 0x06c) that holds no register and must read 0. The default filter length lets a two-clock pulse be dropped and a longer level be accepted within a few cycles. A behavioural model is compared with the read data and both combined outputs on every clock.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned BANK_PINS = 32;
  localparam int unsigned ADDR_W    = 12;
  // Banks beyond this count would overlap the next register kind
  localparam int unsigned MAX_BANKS = 6;

  typedef logic [BANK_PINS-1:0] bank_vec_t;

  typedef enum logic [3:0] {
    SEL_NONE  = 4'd0,
    SEL_RISE  = 4'd1,
    SEL_FALL  = 4'd2,
    SEL_BYP   = 4'd3,
    SEL_MASK  = 4'd4,
    SEL_SRC   = 4'd5,
    SEL_TYPE  = 4'd6,
    SEL_POL   = 4'd7,
    SEL_WMASK = 4'd8,
    SEL_WSRC  = 4'd9
  } reg_sel_t;

  localparam int unsigned NUM_SEL = 9;

  function automatic logic [ADDR_W-1:0] sel_base(reg_sel_t s);
    case (s)
      SEL_RISE:  return 12'h064;
      SEL_FALL:  return 12'h07c;
      SEL_BYP:   return 12'h094;
      SEL_MASK:  return 12'h0ac;
      SEL_SRC:   return 12'h0c4;
      SEL_TYPE:  return 12'h300;
      SEL_POL:   return 12'h318;
      SEL_WMASK: return 12'h400;
      SEL_WSRC:  return 12'h418;
      default:   return 12'hfff;
    endcase
  endfunction

endpackage

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter #(
  parameter int unsigned STABLE_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic clean_o
);
  localparam int unsigned CNT_W = (STABLE_CYCLES > 1) ? $clog2(STABLE_CYCLES + 1) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             clean_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      clean_q <= 1'b0;
    end else if (raw_i == clean_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      clean_q <= raw_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign clean_o = clean_q;

  AST_FILT_TAKES_INPUT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (clean_q == $past(clean_q) || clean_q == $past(raw_i))); // R8
  AST_FILT_HOLDS_EQUAL: assert property (@(posedge clk) disable iff (rst)
    (raw_i == clean_q) |=> $stable(clean_q)); // R8

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned STABLE_CYCLES = 3
) (
  input  logic      clk,
  input  logic      rst,
  input  bank_vec_t pins_i,
  input  logic      wr_en_i,
  input  reg_sel_t  sel_i,
  input  bank_vec_t wr_data_i,
  output bank_vec_t rd_data_o,
  output logic      irq_hit_o,
  output logic      wake_hit_o
);

  bank_vec_t rise_q, fall_q, byp_q, mask_q, lvl_q, pol_q, wmask_q;
  bank_vec_t src_q, wsrc_q, prev_q;
  bank_vec_t filt, eff;
  bank_vec_t edge_hit, lvl_hit, evt;
  bank_vec_t clr_src, clr_wsrc;
  bank_vec_t src_n, wsrc_n;

  // Per-pin stability filters
  for (genvar p = 0; p < BANK_PINS; p++) begin : g_pin
    gpio_irq_filter #(.STABLE_CYCLES(STABLE_CYCLES)) u_filt (
      .clk    (clk),
      .rst    (rst),
      .raw_i  (pins_i[p]),
      .clean_o(filt[p])
    );
  end

  always_comb begin
    eff      = (byp_q & pins_i) | (~byp_q & filt);
    edge_hit = (eff & ~prev_q & rise_q) | (~eff & prev_q & fall_q);
    lvl_hit  = eff ^ pol_q;
    evt      = (lvl_q & lvl_hit) | (~lvl_q & edge_hit);
    clr_src  = (wr_en_i && sel_i == SEL_SRC)  ? wr_data_i : '0;
    clr_wsrc = (wr_en_i && sel_i == SEL_WSRC) ? wr_data_i : '0;
    // Level bits: clear wins this clock; edge bits: a new event wins
    src_n    = (lvl_q & (src_q | evt) & ~clr_src)
             | (~lvl_q & ((src_q & ~clr_src) | evt));
    wsrc_n   = (lvl_q & (wsrc_q | (evt & wmask_q)) & ~clr_wsrc)
             | (~lvl_q & ((wsrc_q & ~clr_wsrc) | (evt & wmask_q)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q  <= '0;
      fall_q  <= '0;
      byp_q   <= '0;
      mask_q  <= '0;
      lvl_q   <= '0;
      pol_q   <= '0;
      wmask_q <= '0;
      src_q   <= '0;
      wsrc_q  <= '0;
      prev_q  <= '0;
    end else begin
      prev_q <= eff;
      src_q  <= src_n;
      wsrc_q <= wsrc_n;
      if (wr_en_i) begin
        case (sel_i)
          SEL_RISE:  rise_q  <= wr_data_i;
          SEL_FALL:  fall_q  <= wr_data_i;
          SEL_BYP:   byp_q   <= wr_data_i;
          SEL_MASK:  mask_q  <= wr_data_i;
          SEL_TYPE:  lvl_q   <= wr_data_i;
          SEL_POL:   pol_q   <= wr_data_i;
          SEL_WMASK: wmask_q <= wr_data_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (sel_i)
      SEL_RISE:  rd_data_o = rise_q;
      SEL_FALL:  rd_data_o = fall_q;
      SEL_BYP:   rd_data_o = byp_q;
      SEL_MASK:  rd_data_o = mask_q;
      SEL_SRC:   rd_data_o = src_q;
      SEL_TYPE:  rd_data_o = lvl_q;
      SEL_POL:   rd_data_o = pol_q;
      SEL_WMASK: rd_data_o = wmask_q;
      SEL_WSRC:  rd_data_o = wsrc_q;
      default:   rd_data_o = '0;
    endcase
  end

  assign irq_hit_o  = |(src_q & mask_q);
  assign wake_hit_o = |wsrc_q;

  AST_EDGE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((src_q & ~$past(src_q) & ~$past(lvl_q) & ~$past(edge_hit)) == '0)); // R6
  AST_LEVEL_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((src_q & $past(lvl_q & clr_src)) == '0)); // R5
  AST_WAKE_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((wsrc_q & ~$past(wsrc_q) & ~$past(wmask_q)) == '0)); // R10

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_BANKS     = 6,
  parameter int unsigned STABLE_CYCLES = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_BANKS*BANK_PINS-1:0] pins_i,
  input  logic                           bus_we_i,
  input  logic [ADDR_W-1:0]              bus_addr_i,
  input  logic [31:0]                    bus_wdata_i,
  output logic [31:0]                    bus_rdata_o,
  output logic                           irq_o,
  output logic                           wake_o
);
  localparam int unsigned BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  reg_sel_t              hit_sel;
  logic [BANK_IDX_W-1:0] hit_bank;
  bank_vec_t             rd_vec   [NUM_BANKS];
  logic [NUM_BANKS-1:0]  irq_hits;
  logic [NUM_BANKS-1:0]  wake_hits;
  logic [31:0]           rdata_q;
  logic                  irq_q, wake_q;

  // Address decode: register kind and bank
  always_comb begin
    hit_sel  = SEL_NONE;
    hit_bank = '0;
    for (int s = 1; s <= NUM_SEL; s++) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bus_addr_i == sel_base(reg_sel_t'(4'(s))) + ADDR_W'(4 * b)) begin
          hit_sel  = reg_sel_t'(4'(s));
          hit_bank = BANK_IDX_W'(b);
        end
      end
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_irq_bank #(.STABLE_CYCLES(STABLE_CYCLES)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .pins_i    (pins_i[b*BANK_PINS +: BANK_PINS]),
      .wr_en_i   (bus_we_i && hit_sel != SEL_NONE && hit_bank == BANK_IDX_W'(b)),
      .sel_i     (hit_sel),
      .wr_data_i (bus_wdata_i),
      .rd_data_o (rd_vec[b]),
      .irq_hit_o (irq_hits[b]),
      .wake_hit_o(wake_hits[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      rdata_q <= (hit_sel == SEL_NONE) ? '0 : rd_vec[hit_bank];
      irq_q   <= |irq_hits;
      wake_q  <= |wake_hits;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = irq_q;
  assign wake_o      = wake_q;

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (hit_sel == SEL_NONE) |=> (bus_rdata_o == '0)); // R11

  initial begin
    AST_BANK_COUNT: assert (NUM_BANKS >= 1 && NUM_BANKS <= MAX_BANKS); // R2
  end

endmodule

// File: tb/tb_gpio_irq_unit.sv
module tb_gpio_irq_unit;
  import gpio_irq_pkg::*;

  localparam int NB = 2;
  localparam int FC = 3;
  localparam int NP = NB * 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pins = '0;
  logic          we = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq, wake;

  always #4 clk = ~clk;

  gpio_irq_unit #(.NUM_BANKS(NB), .STABLE_CYCLES(FC)) dut (
    .clk(clk), .rst(rst), .pins_i(pins), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Model state; kinds: 0 rise,1 fall,2 bypass,3 mask,4 src,5 type,6 pol,7 wmask,8 wsrc
  logic [31:0] m_reg [9][NB];
  bit          m_filt [NP];
  int          m_cnt  [NP];
  bit          m_prev [NP];
  logic [31:0] m_rd;
  bit          m_irq, m_wake;

  function automatic logic [11:0] kind_base(int k);
    case (k)
      0: return 12'h064; 1: return 12'h07c; 2: return 12'h094;
      3: return 12'h0ac; 4: return 12'h0c4; 5: return 12'h300;
      6: return 12'h318; 7: return 12'h400; default: return 12'h418;
    endcase
  endfunction

  function automatic bit decode(logic [11:0] a, output int k, output int b);
    k = 0; b = 0;
    for (int kk = 0; kk < 9; kk++)
      for (int bb = 0; bb < NB; bb++)
        if (a == kind_base(kk) + 12'(4 * bb)) begin k = kk; b = bb; return 1'b1; end
    return 1'b0;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_step();
    int k, b;
    bit hit;
    logic [31:0] nsrc [NB];
    logic [31:0] nwsrc [NB];
    bit eff [NP];
    bit irq_n, wake_n;
    if (rst) begin
      for (int kk = 0; kk < 9; kk++) for (int bb = 0; bb < NB; bb++) m_reg[kk][bb] = '0;
      for (int p = 0; p < NP; p++) begin m_filt[p] = 0; m_cnt[p] = 0; m_prev[p] = 0; end
      m_rd = '0; m_irq = 0; m_wake = 0;
      return;
    end
    hit = decode(addr, k, b);
    irq_n = 0; wake_n = 0;
    for (int bb = 0; bb < NB; bb++) begin
      if ((m_reg[4][bb] & m_reg[3][bb]) != 0) irq_n = 1;
      if (m_reg[8][bb] != 0) wake_n = 1;
    end
    for (int bb = 0; bb < NB; bb++) begin
      for (int i = 0; i < 32; i++) begin
        int p = bb * 32 + i;
        bit ev, lvl, cs, cw, wm, s, w;
        eff[p] = m_reg[2][bb][i] ? pins[p] : m_filt[p];
        lvl = m_reg[5][bb][i];
        if (lvl) ev = eff[p] ^ m_reg[6][bb][i];
        else ev = (eff[p] && !m_prev[p] && m_reg[0][bb][i]) ||
                  (!eff[p] && m_prev[p] && m_reg[1][bb][i]);
        cs = we && hit && k == 4 && b == bb && wdata[i];
        cw = we && hit && k == 8 && b == bb && wdata[i];
        wm = m_reg[7][bb][i];
        s = m_reg[4][bb][i];
        w = m_reg[8][bb][i];
        if (lvl) begin
          nsrc[bb][i]  = (s || ev) && !cs;
          nwsrc[bb][i] = (w || (ev && wm)) && !cw;
        end else begin
          nsrc[bb][i]  = (s && !cs) || ev;
          nwsrc[bb][i] = (w && !cw) || (ev && wm);
        end
      end
    end
    m_rd = hit ? m_reg[k][b] : '0;
    for (int p = 0; p < NP; p++) begin
      if (pins[p] == m_filt[p]) m_cnt[p] = 0;
      else if (m_cnt[p] == FC - 1) begin m_filt[p] = pins[p]; m_cnt[p] = 0; end
      else m_cnt[p]++;
      m_prev[p] = eff[p];
    end
    for (int bb = 0; bb < NB; bb++) begin m_reg[4][bb] = nsrc[bb]; m_reg[8][bb] = nwsrc[bb]; end
    if (we && hit && k != 4 && k != 8) m_reg[k][b] = wdata;
    m_irq = irq_n; m_wake = wake_n;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #2;
    if (!done) begin
      check("R2 read data vs model", rdata, m_rd);
      check("R7 irq vs model", 32'(irq), 32'(m_irq));
      check("R10 wake vs model", 32'(wake), 32'(m_wake));
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic rd_check(string tag, logic [11:0] a, logic [31:0] exp);
    addr = a;
    tick();
    check(tag, rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    // R1: reset state
    check("R1 irq after reset", 32'(irq), 0);
    check("R1 wake after reset", 32'(wake), 0);
    for (int k = 0; k < 9; k++) rd_check("R1 register reset value", kind_base(k) + 12'h4, 0);

    // R2: read back, bank stride
    wr(12'h068, 32'hA5A5_0F0F);
    rd_check("R2 rise bank1 readback", 12'h068, 32'hA5A5_0F0F);
    rd_check("R2 rise bank0 untouched", 12'h064, 0);
    wr(12'h31c, 32'h1234_5678);
    rd_check("R2 polarity bank1 readback", 12'h31c, 32'h1234_5678);
    wr(12'h31c, 0);
    wr(12'h068, 0);
    // R11: unmapped slot
    wr(12'h06c, 32'hFFFF_FFFF);
    rd_check("R11 unmapped read zero", 12'h06c, 0);
    rd_check("R11 neighbour unchanged", 12'h068, 0);

    // R3, R9: bypassed rising edge on pin 0
    wr(12'h094, 32'h1);
    wr(12'h064, 32'h1);
    wr(12'h0ac, 32'h1);
    pins[0] = 1'b1;
    tick();
    pins[0] = pins[0];
    rd_check("R3 R9 rise sets source in one clock", 12'h0c4, 32'h1);
    check("R7 irq high with masked source", 32'(irq), 1);
    // R6: clears
    wr(12'h0c4, 32'h0);
    rd_check("R6 writing zero keeps source", 12'h0c4, 32'h1);
    wr(12'h0c4, 32'h1);
    rd_check("R6 write one clears", 12'h0c4, 0);
    tick();
    rd_check("R6 no re-set without edge", 12'h0c4, 0);
    check("R7 irq low after clear", 32'(irq), 0);

    // R4: falling edge
    wr(12'h07c, 32'h1);
    pins[0] = 1'b0;
    tick();
    rd_check("R4 fall sets source", 12'h0c4, 32'h1);
    wr(12'h0c4, 32'h1);
    // R6: edge coinciding with clear keeps bit
    pins[0] = 1'b1;
    wr(12'h0c4, 32'h1);
    rd_check("R6 edge beats clear", 12'h0c4, 32'h1);
    wr(12'h0c4, 32'h1);
    wr(12'h07c, 0);

    // R8: filtered pin 1
    wr(12'h064, 32'h2);
    pins[1] = 1'b1;
    tick(); tick();
    pins[1] = 1'b0;
    repeat (5) tick();
    rd_check("R8 short pulse dropped", 12'h0c4, 0);
    pins[1] = 1'b1;
    tick(); tick();
    rd_check("R8 not yet passed", 12'h0c4, 0);
    tick(); tick();
    rd_check("R8 stable input passes", 12'h0c4, 32'h2);
    check("R7 unmasked source keeps irq low", 32'(irq), 0);
    wr(12'h0c4, 32'h2);

    // R5: level, active low, bank1 pin 8 (pin 40)
    wr(12'h098, 32'h100);
    wr(12'h31c, 32'h100);
    wr(12'h304, 32'h100);
    tick();
    rd_check("R5 active-low level sets", 12'h0c8, 32'h100);
    wr(12'h0c8, 32'h100);
    rd_check("R5 cleared for one clock", 12'h0c8, 0);
    rd_check("R5 re-sets while active", 12'h0c8, 32'h100);
    pins[40] = 1'b1;
    tick();
    wr(12'h0c8, 32'h100);
    tick();
    rd_check("R5 stays clear when inactive", 12'h0c8, 0);

    // R10: wake on bank1 pin 8
    wr(12'h0b0, 32'h100);
    wr(12'h404, 32'h100);
    pins[40] = 1'b0;
    tick(); tick();
    check("R10 wake output high", 32'(wake), 1);
    check("R7 irq from bank1", 32'(irq), 1);
    rd_check("R10 wake source bank1", 12'h41c, 32'h100);
    rd_check("R10 unmasked bank0 wake stays zero", 12'h418, 0);
    pins[40] = 1'b1;
    tick();
    wr(12'h41c, 32'h100);
    wr(12'h0c8, 32'h100);
    tick(); tick();
    check("R10 wake low after clear", 32'(wake), 0);
    rd_check("R10 wake source cleared", 12'h41c, 0);
    repeat (4) tick();
    finish_run();
  end

endmodule